// File: doc/BRIEF.md
# Processor clock source selector and ratio divider

This block derives a processor clock from two free-running inputs: a fast PLL clock and a slower crystal reference. A source multiplexer picks one of the two to feed a divider. The divider offers four ratios: straight through, halving, division by three, and division by twice a programmable count. An output multiplexer then selects either the divider result or the raw crystal clock. Both multiplexers are glitch-free clock switches, so a select change never puts a pulse narrower than half a source period on the output.

Software controls the block through two 32-bit words on a simple write/read port clocked by the crystal. While the PLL is retuned, the output is parked on the crystal and the divider settings are changed only in that state. A status output always reports the division ratio implied by the stored fields.

Top module: `cpu_clk_divsel`

## Requirements
- R1: The word at byte address 0x00 (count word, count N in bits 28:20) and the word at 0x40 (control word: bit 0 source pick, bits 3:2 ratio mode, bit 7 output pick) read back exactly as written on all 32 bits. Bits outside those fields have no effect on the ratio or the clock.
- R2: A write to any other address changes neither stored word, and reads of such addresses return zero.
- R3: `div_ratio` equals mode+1 for mode 0, 1 and 2, and equals 2·N for mode 3. It follows a control-word write from the next crystal edge on.
- R4: After reset both words read zero, `div_ratio` is 1 and `cpu_clk` runs at the crystal period.
- R5: With control bit 7 clear, `cpu_clk` is the crystal clock whatever the divider and source fields hold.
- R6: With control bit 0 set the divider is fed by the PLL clock; with it clear, by the crystal clock.
- R7: With bit 7 set, mode 0 passes the source clock unchanged and mode 1 gives twice its period with a 50% duty cycle.
- R8: Mode 2 gives three source periods, high for exactly one and a half of them.
- R9: Mode 3 with N ≥ 1 gives 2·N source periods, high for exactly N of them. N is ignored in modes 0 to 2.
- R10: Mode 3 with N = 0 holds the divided clock low with no edges.
- R11: Neither multiplexer ever enables both of its inputs at once. No pulse on `cpu_clk` is shorter than half the fastest source period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xtal_clk | input | 1 | Crystal reference clock, also clocks the register port |
| pll_clk | input | 1 | Fast PLL clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 7 | Byte address of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cpu_clk | output | 1 | Generated processor clock |
| div_ratio | output | 10 | Division ratio implied by the stored fields |

## Verification
The divider is run through every ratio mode with each source. This includes N = 1, which must equal mode 1, a mid-range N, and the largest N. Period and high time are measured separately, so a wrong ratio shows up apart from a skewed duty cycle. Parking the output on the crystal with a PLL-fed divider configured tells the output pick apart from the source pick. Setting N = 0 while the output runs from the divider shows whether the stop condition leaks edges. A running minimum of `cpu_clk` pulse widths across all switches exposes any runt left by a multiplexer handover.

// File: rtl/cpu_clk_pkg.sv
package cpu_clk_pkg;

  localparam int unsigned N_W     = 9;
  localparam int unsigned RATIO_W = N_W + 1;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 7;

  localparam logic [ADDR_W-1:0] ADDR_COUNT = 7'h00;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 7'h40;

  localparam int unsigned N_LSB    = 20;
  localparam int unsigned MODE_LSB = 2;
  localparam int unsigned SRC_BIT  = 0;
  localparam int unsigned OUT_BIT  = 7;

  typedef enum logic [1:0] {
    DIV_BY1  = 2'd0,
    DIV_BY2  = 2'd1,
    DIV_BY3  = 2'd2,
    DIV_BY2N = 2'd3
  } div_mode_e;

  function automatic logic [RATIO_W-1:0] eff_ratio(div_mode_e mode, logic [N_W-1:0] n);
    if (mode == DIV_BY2N) return {n, 1'b0};
    return {{(RATIO_W-2){1'b0}}, mode} + {{(RATIO_W-1){1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/clk_rst_sync.sv
module clk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  assign pipe_d = {pipe_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign rst_n_o = pipe_q[STAGES-1];

endmodule

// File: rtl/cpu_clk_regs.sv
module cpu_clk_regs #(
  parameter int unsigned       ADDR_W = 7,
  parameter int unsigned       DATA_W = 32,
  parameter logic [ADDR_W-1:0] A_COUNT = '0,
  parameter logic [ADDR_W-1:0] A_CTRL  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] ctrl_o
);

  localparam int unsigned NREG = 2;
  localparam logic [ADDR_W-1:0] MAP [NREG] = '{A_COUNT, A_CTRL};

  logic [NREG-1:0]   hit;
  logic [NREG-1:0]   wen;
  logic [DATA_W-1:0] word_q [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_word
    assign hit[r] = (addr == MAP[r]);
    assign wen[r] = wr & hit[r];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word_q[r] <= '0;
      else if (wen[r]) word_q[r] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NREG; r++) begin
      if (hit[r]) rdata = rdata | word_q[r];
    end
  end

  assign count_o = word_q[0];
  assign ctrl_o  = word_q[1];

endmodule

// File: rtl/clk_glitchless_mux.sv
module clk_glitchless_mux #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk0,
  input  logic       clk1,
  input  logic       rst0_n,
  input  logic       rst1_n,
  input  logic       sel,
  output logic       clk_o,
  output logic [1:0] en_o
);

  localparam int unsigned NSRC = 2;

  logic [NSRC-1:0] clk_v;
  logic [NSRC-1:0] rst_v;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] en;

  assign clk_v = {clk1, clk0};
  assign rst_v = {rst1_n, rst0_n};

  // An input may only be requested once the other one has let go.
  assign req[0] = ~sel & ~en[1];
  assign req[1] =  sel & ~en[0];

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic                   gclk;
    logic                   grst_n;
    logic [SYNC_STAGES-1:0] sync_q;
    logic [SYNC_STAGES-1:0] sync_d;
    logic                   en_q;

    assign gclk   = clk_v[g];
    assign grst_n = rst_v[g];
    assign sync_d = {sync_q[SYNC_STAGES-2:0], req[g]};

    always_ff @(posedge gclk or negedge grst_n) begin
      if (!grst_n) sync_q <= '0;
      else         sync_q <= sync_d;
    end

    // Enable changes only while this source is low.
    always_ff @(negedge gclk or negedge grst_n) begin
      if (!grst_n) en_q <= 1'b0;
      else         en_q <= sync_q[SYNC_STAGES-1];
    end

    assign en[g] = en_q;
  end

  assign clk_o = |(clk_v & en);
  assign en_o  = en;

endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div
  import cpu_clk_pkg::*;
#(
  parameter int unsigned N_BITS      = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_a,
  input  logic [N_BITS-1:0] n_a,
  output logic              div_clk_o,
  output logic [1:0]        mode_q_o,
  output logic [N_BITS-1:0] n_q_o
);

  localparam int unsigned CFG_W = N_BITS + 2;

  // Configuration is quasi-static: it only changes while the output is parked.
  logic [SYNC_STAGES-1:0][CFG_W-1:0] cfg_q;
  logic [SYNC_STAGES-1:0][CFG_W-1:0] cfg_d;
  div_mode_e                         mode;
  logic [N_BITS-1:0]                 n_q;

  assign cfg_d = {cfg_q[SYNC_STAGES-2:0], {mode_a, n_a}};
  assign mode  = div_mode_e'(cfg_q[SYNC_STAGES-1][CFG_W-1:N_BITS]);
  assign n_q   = cfg_q[SYNC_STAGES-1][N_BITS-1:0];

  logic              half_q, half_d;
  logic [2:0]        ring_q, ring_d;
  logic              neg3_q;
  logic [N_BITS-1:0] cnt_q, cnt_d;
  logic              even_q, even_d;

  always_comb begin
    half_d = ~half_q;
    ring_d = {ring_q[1:0], ring_q[2]};
    if (n_q == '0) begin
      cnt_d  = '0;
      even_d = 1'b0;
    end else if (cnt_q >= n_q - 1'b1) begin
      cnt_d  = '0;
      even_d = ~even_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      even_d = even_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      half_q <= 1'b0;
      ring_q <= 3'b001;
      cnt_q  <= '0;
      even_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      half_q <= half_d;
      ring_q <= ring_d;
      cnt_q  <= cnt_d;
      even_q <= even_d;
    end
  end

  // Half-cycle-late copy stretches the one-in-three pulse to 1.5 periods.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg3_q <= 1'b0;
    else        neg3_q <= ring_q[0];
  end

  always_comb begin
    unique case (mode)
      DIV_BY1: div_clk_o = clk;
      DIV_BY2: div_clk_o = half_q;
      DIV_BY3: div_clk_o = ring_q[0] | neg3_q;
      default: div_clk_o = even_q;
    endcase
  end

  assign mode_q_o = mode;
  assign n_q_o    = n_q;

endmodule

// File: rtl/cpu_clk_divsel.sv
module cpu_clk_divsel
  import cpu_clk_pkg::*;
#(
  parameter int unsigned ADDR_BITS   = cpu_clk_pkg::ADDR_W,
  parameter int unsigned DATA_BITS   = cpu_clk_pkg::DATA_W,
  parameter int unsigned N_BITS      = cpu_clk_pkg::N_W,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned R_BITS     = N_BITS + 1
) (
  input  logic                 xtal_clk,
  input  logic                 pll_clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_BITS-1:0] bus_addr,
  input  logic [DATA_BITS-1:0] bus_wdata,
  output logic [DATA_BITS-1:0] bus_rdata,
  output logic                 cpu_clk,
  output logic [R_BITS-1:0]    div_ratio
);

  logic xtal_rst_n, pll_rst_n, src_rst_n, div_rst_n;
  logic [DATA_BITS-1:0] count_q, ctrl_q;
  logic [N_BITS-1:0]    n_field;
  div_mode_e            mode_field;
  logic                 src_pick, out_pick;
  logic                 src_clk, div_clk;
  logic [1:0]           src_en, out_en;
  logic [1:0]           div_sel_q;
  logic [N_BITS-1:0]    div_n_q;

  clk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_xtal (.clk(xtal_clk), .arst_n(rst_n), .rst_n_o(xtal_rst_n));
  clk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_pll  (.clk(pll_clk),  .arst_n(rst_n), .rst_n_o(pll_rst_n));
  clk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_src  (.clk(src_clk),  .arst_n(rst_n), .rst_n_o(src_rst_n));
  clk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_div  (.clk(div_clk),  .arst_n(rst_n), .rst_n_o(div_rst_n));

  cpu_clk_regs #(
    .ADDR_W (ADDR_BITS),
    .DATA_W (DATA_BITS),
    .A_COUNT(ADDR_BITS'(ADDR_COUNT)),
    .A_CTRL (ADDR_BITS'(ADDR_CTRL))
  ) u_regs (
    .clk    (xtal_clk),
    .rst_n  (xtal_rst_n),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .count_o(count_q),
    .ctrl_o (ctrl_q)
  );

  assign n_field    = count_q[N_LSB +: N_BITS];
  assign mode_field = div_mode_e'(ctrl_q[MODE_LSB +: 2]);
  assign src_pick   = ctrl_q[SRC_BIT];
  assign out_pick   = ctrl_q[OUT_BIT];
  assign div_ratio  = R_BITS'(eff_ratio(mode_field, n_field));

  clk_glitchless_mux #(.SYNC_STAGES(SYNC_STAGES)) u_src_mux (
    .clk0  (xtal_clk),
    .clk1  (pll_clk),
    .rst0_n(xtal_rst_n),
    .rst1_n(pll_rst_n),
    .sel   (src_pick),
    .clk_o (src_clk),
    .en_o  (src_en)
  );

  clk_ratio_div #(.N_BITS(N_BITS), .SYNC_STAGES(SYNC_STAGES)) u_div (
    .clk      (src_clk),
    .rst_n    (src_rst_n),
    .mode_a   (mode_field),
    .n_a      (n_field),
    .div_clk_o(div_clk),
    .mode_q_o (div_sel_q),
    .n_q_o    (div_n_q)
  );

  clk_glitchless_mux #(.SYNC_STAGES(SYNC_STAGES)) u_out_mux (
    .clk0  (xtal_clk),
    .clk1  (div_clk),
    .rst0_n(xtal_rst_n),
    .rst1_n(div_rst_n),
    .sel   (out_pick),
    .clk_o (cpu_clk),
    .en_o  (out_en)
  );

endmodule

// File: rtl/cpu_clk_divsel_chk.sv
module cpu_clk_divsel_chk
  import cpu_clk_pkg::*;
#(
  parameter int unsigned N_BITS = 9,
  parameter int unsigned A_BITS = 7,
  parameter int unsigned D_BITS = 32
) (
  input logic              xtal_clk,
  input logic              reg_rst_n,
  input logic              bus_wr,
  input logic [A_BITS-1:0] bus_addr,
  input logic [D_BITS-1:0] bus_wdata,
  input logic [N_BITS:0]   div_ratio,
  input logic              src_clk,
  input logic              src_rst_n,
  input logic [1:0]        src_en,
  input logic [1:0]        out_en,
  input logic [1:0]        div_sel_q,
  input logic [N_BITS-1:0] div_n_q,
  input logic              div_clk
);

  // R4: while the register domain is in reset the ratio reads as one
  always @(posedge xtal_clk) begin
    if (!reg_rst_n) assert_reset_ratio_R4: assert (div_ratio == (N_BITS+1)'(1));
  end

  assert_ratio_follows_mode_R3: assert property (@(posedge xtal_clk) disable iff (!reg_rst_n)
    (bus_wr && bus_addr == A_BITS'(ADDR_CTRL) && bus_wdata[MODE_LSB +: 2] != 2'b11)
    |=> (div_ratio == (N_BITS+1)'($past(bus_wdata[MODE_LSB +: 2])) + 1'b1));

  assert_src_break_before_make_R11: assert property (@(posedge xtal_clk) disable iff (!reg_rst_n)
    $onehot0(src_en));

  assert_out_break_before_make_R11: assert property (@(posedge xtal_clk) disable iff (!reg_rst_n)
    $onehot0(out_en));

  assert_zero_count_holds_low_R10: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (div_sel_q == 2'b11 && div_n_q == '0)
    |=> (div_sel_q != 2'b11 || div_n_q != '0 || !div_clk));

endmodule

bind cpu_clk_divsel cpu_clk_divsel_chk #(
  .N_BITS(N_BITS),
  .A_BITS(ADDR_BITS),
  .D_BITS(DATA_BITS)
) u_chk (
  .xtal_clk (xtal_clk),
  .reg_rst_n(xtal_rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .div_ratio(div_ratio),
  .src_clk  (src_clk),
  .src_rst_n(src_rst_n),
  .src_en   (src_en),
  .out_en   (out_en),
  .div_sel_q(div_sel_q),
  .div_n_q  (div_n_q),
  .div_clk  (div_clk)
);

// File: tb/cpu_clk_divsel_test.sv
module cpu_clk_divsel_test;

  localparam longint XT = 20;   // crystal period, 50 MHz
  localparam longint PT = 6;    // PLL period
  localparam int NVEC = 9;

  // {mode[21:20], N[19:11], src[10], expected ratio[9:0]}
  localparam logic [21:0] STIM [NVEC] = '{
    {2'd0, 9'd0,   1'b1, 10'd1},
    {2'd1, 9'd0,   1'b1, 10'd2},
    {2'd2, 9'd0,   1'b1, 10'd3},
    {2'd3, 9'd1,   1'b1, 10'd2},
    {2'd3, 9'd5,   1'b1, 10'd10},
    {2'd3, 9'd4,   1'b0, 10'd8},
    {2'd2, 9'd0,   1'b0, 10'd3},
    {2'd3, 9'd511, 1'b1, 10'd1022},
    {2'd1, 9'd7,   1'b0, 10'd2}
  };

  logic        xtal_clk = 1'b0;
  logic        pll_clk  = 1'b0;
  logic        rst_n    = 1'b0;
  logic        bus_wr   = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_clk;
  logic [9:0]  div_ratio;

  int checks = 0;
  int errors = 0;
  longint last_edge = -1;
  longint min_pulse = 1000000;
  int rises = 0;
  longint last_period = XT;

  always #(XT/2) xtal_clk = ~xtal_clk;
  always #(PT/2) pll_clk  = ~pll_clk;

  cpu_clk_divsel uut (
    .xtal_clk (xtal_clk),
    .pll_clk  (pll_clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cpu_clk  (cpu_clk),
    .div_ratio(div_ratio)
  );

  always @(posedge cpu_clk or negedge cpu_clk) begin
    if (last_edge >= 0 && ($time - last_edge) < min_pulse) min_pulse = $time - last_edge;
    last_edge = $time;
  end

  always @(posedge cpu_clk) rises++;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge xtal_clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge xtal_clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge xtal_clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic measure(output longint per, output longint hi);
    longint t0, t1, t2;
    repeat (2) @(posedge cpu_clk);
    @(posedge cpu_clk); t0 = $time;
    @(negedge cpu_clk); t1 = $time;
    @(posedge cpu_clk); t2 = $time;
    per = t2 - t0;
    hi  = t1 - t0;
    last_period = per;
  endtask

  function automatic logic [31:0] ctrl_word(input logic o, input logic [1:0] m, input logic s);
    return (32'(o) << 7) | (32'(m) << 2) | 32'(s);
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    if (m == 2'd2) return "R8";
    if (m == 2'd3) return "R9";
    return "R7";
  endfunction

  // Park on the crystal, change the divider, then return to the divider path.
  task automatic setup(input logic [1:0] m, input logic [8:0] n, input logic s, input logic o);
    logic [31:0] cur;
    rd(7'h40, cur);
    wr(7'h40, cur & ~32'h80);
    #(2 * last_period + 400);
    wr(7'h00, 32'(n) << 20);
    wr(7'h40, ctrl_word(1'b0, m, s));
    repeat (40) @(posedge xtal_clk);
    if (o) begin
      wr(7'h40, ctrl_word(1'b1, m, s));
      repeat (20) @(posedge xtal_clk);
    end
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    longint per, hi;
    int r0;

    repeat (3) @(posedge xtal_clk);
    @(negedge xtal_clk) rst_n = 1'b1;
    repeat (10) @(posedge xtal_clk);

    // R4: reset state
    rd(7'h00, d); check("R4", "count word after reset", d, 0);
    rd(7'h40, d); check("R4", "control word after reset", d, 0);
    #1 check("R4", "ratio after reset", div_ratio, 1);
    measure(per, hi); check("R4", "crystal period after reset", per, XT);

    // R1: readback and unused bits
    wr(7'h00, 32'hA5A5_5A5A);
    rd(7'h00, d); check("R1", "count word readback", d, 32'hA5A5_5A5A);
    wr(7'h40, 32'h0000_F070);
    rd(7'h40, d); check("R1", "control word readback", d, 32'h0000_F070);
    #1 check("R1", "unused control bits leave ratio", div_ratio, 1);
    measure(per, hi); check("R1", "unused control bits leave clock", per, XT);

    // R2: unmapped address
    wr(7'h20, 32'hFFFF_FFFF);
    rd(7'h20, d); check("R2", "unmapped read", d, 0);
    rd(7'h00, d); check("R2", "count word kept", d, 32'hA5A5_5A5A);
    rd(7'h40, d); check("R2", "control word kept", d, 32'h0000_F070);

    // R5: PLL divider configured but output left on the crystal
    setup(2'd1, 9'd0, 1'b1, 1'b0);
    #1 check("R3", "ratio with mode 1", div_ratio, 2);
    measure(per, hi); check("R5", "bypass period", per, XT);
    check("R5", "bypass high time", hi, XT/2);

    // Table walk: R3, R6, R7, R8, R9
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] m  = STIM[i][21:20];
      logic [8:0] n  = STIM[i][19:11];
      logic       s  = STIM[i][10];
      longint     r  = longint'(STIM[i][9:0]);
      longint     sp = s ? PT : XT;
      setup(m, n, s, 1'b1);
      rd(7'h40, d); check("R1", "control readback in table", d, ctrl_word(1'b1, m, s));
      check("R3", "ratio status", div_ratio, r);
      measure(per, hi);
      check(s ? mode_tag(m) : "R6", "period", per, sp * r);
      check(mode_tag(m), "high time", hi, sp * r / 2);
    end

    // R10: N of zero in mode 3 stops the divided clock low
    setup(2'd3, 9'd3, 1'b1, 1'b1);
    measure(per, hi); check("R9", "period with N 3", per, 6 * PT);
    wr(7'h00, 32'h0);
    repeat (10) @(posedge xtal_clk);
    #1 check("R3", "ratio with N 0", div_ratio, 0);
    r0 = rises;
    repeat (25) @(posedge xtal_clk);
    #1 check("R10", "edges with N 0", rises - r0, 0);
    check("R10", "level with N 0", cpu_clk, 0);
    wr(7'h00, 32'(9'd3) << 20);
    measure(per, hi); check("R10", "clock resumes with N 3", per, 6 * PT);

    // Back to the crystal, then R11 pulse width over the whole run
    setup(2'd0, 9'd0, 1'b0, 1'b0);
    measure(per, hi); check("R5", "final crystal period", per, XT);
    check("R11", "no runt pulse", (min_pulse >= PT/2) ? 1 : 0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule